// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. A single strobe input has two jobs. Its rising edge clears the previous result and raises the busy flag. Its falling edge starts the bit search. During the search the block drives a trial code to an external DAC. It reads back one comparator decision per bit period, working from the most significant bit down to the least significant bit. When the last bit has been decided, the busy flag drops and the code held in the register is the result.

The result leaves the block on two byte lanes. The upper lane carries the top bits and the lower lane carries the bottom bits. Each lane has its own active-low enable. Tri-state drivers are modelled as a data value plus an output-enable flag for each lane, so the block stays synthesizable. Tying both enables to the busy flag gives stand-alone operation: the lanes float while a conversion runs and drive the result as soon as it is final. A mode input selects bipolar operation. The block samples it when a conversion is armed and presents it to the DAC as an offset request, which turns the result into offset binary.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `dr` is 0, `trial_code` is 0 and both lane enables `bus_hi_oe`/`bus_lo_oe` are 0 when `hbe_n`/`lbe_n` are 1.
- R2: A clock edge that first samples `convert` high leaves `dr` = 1 and `trial_code` = 0 after that edge, whatever state the block was in.
- R3: While `convert` stays high, no trial starts: `trial_code` stays 0 and `dr` stays 1.
- R4: The edge that first samples `convert` low after an arming edge loads `trial_code` with only bit NBITS-1 set (0x200). Every BIT_DIV cycles after that, the bit under trial is cleared if `cmp_hi` is 1 (DAC value above the input) and kept otherwise. At the same time the next lower bit is set on trial.
- R5: With an ideal comparator, the final code is the largest code whose DAC value does not exceed the input. For a unipolar input this is the input clamped to 0..1023.
- R6: Counting the edge that first samples `convert` low as edge 0, `dr` is low after edge 10·BIT_DIV+1. After that, `trial_code` holds its value until the next arming edge.
- R7: `dac_bipolar` takes the value of `bipolar_sel` on the arming edge and ignores later changes until the next arming edge. With the DAC offset by 512 codes, input 0 gives 0x200, the most negative input (-512) gives 0 and the most positive input (+511) gives 0x3FF.
- R8: `bus_hi` = `trial_code[9:2]` with `bus_hi_oe` = NOT `hbe_n`. `bus_lo` = `trial_code[1:0]` with `bus_lo_oe` = NOT `lbe_n`. The two lanes are enabled independently.
- R9: An enable asserted during a conversion exposes the partial register contents on its lane.
- R10: With `hbe_n` and `lbe_n` both tied to `dr`, both lanes are disabled during a conversion and carry the final result once `dr` drops.
- R11: A new rising edge of `convert` during a conversion aborts it. The code returns to 0, `dr` stays 1, and the search restarts only on the next falling edge.
- R12: A falling edge of `convert` with no preceding arming edge (for example `convert` held high through reset) is ignored: `dr` and `trial_code` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| convert | input | 1 | Conversion strobe: rising edge arms, falling edge starts |
| cmp_hi | input | 1 | Comparator: 1 when the DAC value exceeds the input |
| bipolar_sel | input | 1 | Mode request, sampled on arming |
| hbe_n | input | 1 | Active-low enable of the upper lane |
| lbe_n | input | 1 | Active-low enable of the lower lane |
| trial_code | output | NBITS | Code driven to the DAC |
| dac_bipolar | output | 1 | Offset request to the DAC for the current conversion |
| dr | output | 1 | Busy flag: high from arming until the result is final |
| bus_hi | output | NBITS-LO_BITS | Upper lane data |
| bus_hi_oe | output | 1 | Upper lane drive enable |
| bus_lo | output | LO_BITS | Lower lane data |
| bus_lo_oe | output | 1 | Lower lane drive enable |

## Verification
The arming edge shows up one edge later: `dr` is high and the code is cleared at the next falling clock edge. The MSB trial is due one edge after `convert` is sampled low. Each further decision is due BIT_DIV edges later, and `dr` drops 10·BIT_DIV+1 edges after the start edge. The bench drives inputs on falling clock edges and counts falling edges from the start drive, so it samples each partial code and the drop of `dr` in exactly the cycle these counts predict. The lane enables are combinational, so lane checks are taken a short delay after the enables change.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_ARM,
        CT_RUN,
        CT_FIN
    } ctl_state_t;

    typedef struct packed {
        logic clear;
        logic load_first;
        logic decide;
    } sar_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sar_edge.sv
module sar_edge (
    input  logic clk,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    // Follows the strobe even during reset, so a level held through
    // reset never looks like a fresh edge afterwards.
    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int BIT_DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rise,
    input  logic     fall,
    input  logic     last,
    output sar_cmd_t cmd,
    output logic     busy
);
    localparam int unsigned CW = cnt_width(BIT_DIV);
    localparam logic [CW-1:0] CNT_MAX = CW'(BIT_DIV - 1);

    ctl_state_t      st, st_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    always_comb begin
        cmd     = '0;
        st_nxt  = st;
        cnt_nxt = cnt;
        if (rise) begin
            cmd.clear = 1'b1;
            st_nxt    = CT_ARM;
            cnt_nxt   = '0;
        end else begin
            unique case (st)
                CT_ARM: begin
                    if (fall) begin
                        cmd.load_first = 1'b1;
                        st_nxt         = CT_RUN;
                        cnt_nxt        = '0;
                    end
                end
                CT_RUN: begin
                    if (cnt == CNT_MAX) begin
                        cmd.decide = 1'b1;
                        cnt_nxt    = '0;
                        if (last) st_nxt = CT_FIN;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                CT_FIN:  st_nxt = CT_IDLE;
                default: st_nxt = CT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CT_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    assign busy = (st != CT_IDLE);
endmodule

// File: rtl/sar_shift.sv
module sar_shift
    import sar_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_cmd_t         cmd,
    input  logic             drop,
    output logic [NBITS-1:0] code,
    output logic [NBITS-1:0] ptr,
    output logic             last
);
    // One cell per bit: a result flop and a one-hot trial pointer flop.
    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        logic from_above;
        if (i == NBITS - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_mid
            assign from_above = ptr[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst || cmd.clear) begin
                code[i] <= 1'b0;
                ptr[i]  <= 1'b0;
            end else if (cmd.load_first) begin
                code[i] <= (i == NBITS - 1);
                ptr[i]  <= (i == NBITS - 1);
            end else if (cmd.decide) begin
                if (ptr[i] && drop) code[i] <= 1'b0;
                else if (from_above) code[i] <= 1'b1;
                ptr[i] <= from_above;
            end
        end
    end

    assign last = ptr[0];
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_pkg::*;
#(
    parameter int NBITS   = 10,
    parameter int LO_BITS = 2,
    parameter int BIT_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     convert,
    input  logic                     cmp_hi,
    input  logic                     bipolar_sel,
    input  logic                     hbe_n,
    input  logic                     lbe_n,
    output logic [NBITS-1:0]         trial_code,
    output logic                     dac_bipolar,
    output logic                     dr,
    output logic [NBITS-LO_BITS-1:0] bus_hi,
    output logic                     bus_hi_oe,
    output logic [LO_BITS-1:0]       bus_lo,
    output logic                     bus_lo_oe
);
    localparam int HI_BITS = NBITS - LO_BITS;

    logic             conv_rise, conv_fall;
    logic             last_bit;
    logic [NBITS-1:0] trial_ptr;
    sar_cmd_t         cmd;

    sar_edge u_edge (
        .clk  (clk),
        .sig  (convert),
        .rise (conv_rise),
        .fall (conv_fall)
    );

    sar_ctrl #(.BIT_DIV(BIT_DIV)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .rise (conv_rise),
        .fall (conv_fall),
        .last (last_bit),
        .cmd  (cmd),
        .busy (dr)
    );

    sar_shift #(.NBITS(NBITS)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .drop (cmp_hi),
        .code (trial_code),
        .ptr  (trial_ptr),
        .last (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)            dac_bipolar <= 1'b0;
        else if (conv_rise) dac_bipolar <= bipolar_sel;
    end

    assign bus_hi    = trial_code[NBITS-1 -: HI_BITS];
    assign bus_lo    = trial_code[LO_BITS-1:0];
    assign bus_hi_oe = ~hbe_n;
    assign bus_lo_oe = ~lbe_n;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             convert,
    input logic             dr,
    input logic [NBITS-1:0] trial_code,
    input logic [NBITS-1:0] trial_ptr,
    input logic             dac_bipolar,
    input logic             conv_rise,
    input logic             conv_fall
);
    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(convert) |=> (dr && trial_code == '0));

    assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trial_ptr));

    assert_ptr_bit_set_R4: assert property (@(posedge clk) disable iff (rst)
        (trial_ptr != '0) |-> ((trial_code & trial_ptr) != '0));

    assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!dr && $past(!dr)) |-> $stable(trial_code));

    assert_mode_latched_R7: assert property (@(posedge clk) disable iff (rst)
        (dr && !$past(conv_rise)) |-> $stable(dac_bipolar));

    assert_idle_fall_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (!dr && conv_fall) |=> !dr);
endmodule

bind sar_seq_top sar_seq_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;
    localparam int NB = 10;
    localparam int D  = 4;
    localparam int DONE_EDGES = 10 * D + 2;

    logic clk = 1'b0;
    logic rst, convert, bipolar_sel, hbe_drv, lbe_drv, sa_mode;
    logic cmp_hi, hbe_n, lbe_n;
    logic [NB-1:0] trial_code;
    logic dac_bipolar, dr, bus_hi_oe, bus_lo_oe;
    logic [7:0] bus_hi;
    logic [1:0] bus_lo;
    int ain;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign hbe_n = sa_mode ? dr : hbe_drv;
    assign lbe_n = sa_mode ? dr : lbe_drv;

    // Ideal DAC and comparator
    always_comb begin
        int dac_v;
        dac_v  = int'(trial_code) - (dac_bipolar ? 512 : 0);
        cmp_hi = (dac_v > ain);
    end

    sar_seq_top #(.NBITS(NB), .LO_BITS(2), .BIT_DIV(D)) u0 (
        .clk(clk), .rst(rst), .convert(convert), .cmp_hi(cmp_hi),
        .bipolar_sel(bipolar_sel), .hbe_n(hbe_n), .lbe_n(lbe_n),
        .trial_code(trial_code), .dac_bipolar(dac_bipolar), .dr(dr),
        .bus_hi(bus_hi), .bus_hi_oe(bus_hi_oe),
        .bus_lo(bus_lo), .bus_lo_oe(bus_lo_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ideal(input int a, input bit bip);
        int v;
        v = bip ? a + 512 : a;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic int partial(input int fin, input int m);
        int mask;
        mask = ((1 << m) - 1) << (10 - m);
        return (fin & mask) | ((m < 10) ? (1 << (9 - m)) : 0);
    endfunction

    task automatic arm(input int hold);
        @(negedge clk) convert = 1'b1;
        @(negedge clk);
        chk("R2 dr after arm", int'(dr), 1);
        chk("R2 code cleared", int'(trial_code), 0);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk("R3 code idle while high", int'(trial_code), 0);
            chk("R3 dr held", int'(dr), 1);
        end
        convert = 1'b0;
    endtask

    task automatic await_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (dr && n < 1000);
    endtask

    task automatic test_reset();
        rst = 1'b1; convert = 1'b0; bipolar_sel = 1'b0;
        hbe_drv = 1'b1; lbe_drv = 1'b1; sa_mode = 1'b0; ain = 0;
        repeat (4) @(negedge clk);
        chk("R1 dr in reset", int'(dr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dr", int'(dr), 0);
        chk("R1 code", int'(trial_code), 0);
        chk("R1 hi oe", int'(bus_hi_oe), 0);
        chk("R1 lo oe", int'(bus_lo_oe), 0);
    endtask

    task automatic test_idle_fall();
        rst = 1'b1; convert = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        convert = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 dr after stray fall", int'(dr), 0);
        chk("R12 code after stray fall", int'(trial_code), 0);
    endtask

    task automatic test_convert(input int a, input bit bip, input int hold);
        int n;
        ain = a; bipolar_sel = bip;
        arm(hold);
        await_done(n);
        chk("R6 edges to dr low", n, DONE_EDGES);
        chk(bip ? "R7 bipolar result" : "R5 unipolar result",
            int'(trial_code), ideal(a, bip));
        repeat (5) @(negedge clk);
        chk("R6 result held", int'(trial_code), ideal(a, bip));
    endtask

    task automatic test_trace(input int a);
        int fin, n;
        ain = a; bipolar_sel = 1'b0;
        fin = ideal(a, 1'b0);
        arm(1);
        @(negedge clk);
        chk("R4 msb trial", int'(trial_code), 512);
        for (int m = 1; m <= 10; m++) begin
            repeat (D) @(negedge clk);
            chk("R4 partial code", int'(trial_code), partial(fin, m));
        end
        await_done(n);
        chk("R6 final edge", n, 1);
    endtask

    task automatic test_mode_latch();
        int n;
        ain = 0;
        @(negedge clk) begin bipolar_sel = 1'b1; convert = 1'b1; end
        @(negedge clk) begin bipolar_sel = 1'b0; convert = 1'b0; end
        await_done(n);
        chk("R7 dac_bipolar latched", int'(dac_bipolar), 1);
        chk("R7 zero input code", int'(trial_code), 512);
    endtask

    task automatic test_lanes();
        test_convert(677, 1'b0, 1);
        hbe_drv = 1'b0; lbe_drv = 1'b1;
        #1;
        chk("R8 hi oe", int'(bus_hi_oe), 1);
        chk("R8 lo oe off", int'(bus_lo_oe), 0);
        chk("R8 hi data", int'(bus_hi), 677 >> 2);
        hbe_drv = 1'b1; lbe_drv = 1'b0;
        #1;
        chk("R8 hi oe off", int'(bus_hi_oe), 0);
        chk("R8 lo oe", int'(bus_lo_oe), 1);
        chk("R8 lo data", int'(bus_lo), 677 & 3);
        lbe_drv = 1'b1;
    endtask

    task automatic test_partial();
        int n, p;
        ain = 677; bipolar_sel = 1'b0;
        hbe_drv = 1'b0; lbe_drv = 1'b0;
        arm(1);
        @(negedge clk);
        repeat (3 * D) @(negedge clk);
        p = partial(677, 3);
        chk("R9 partial hi oe", int'(bus_hi_oe), 1);
        chk("R9 partial hi data", int'(bus_hi), p >> 2);
        chk("R9 partial lo data", int'(bus_lo), p & 3);
        await_done(n);
        hbe_drv = 1'b1; lbe_drv = 1'b1;
    endtask

    task automatic test_standalone();
        int n;
        sa_mode = 1'b1; ain = 345; bipolar_sel = 1'b0;
        arm(2);
        repeat (D * 5) @(negedge clk);
        chk("R10 hi off while busy", int'(bus_hi_oe), 0);
        chk("R10 lo off while busy", int'(bus_lo_oe), 0);
        await_done(n);
        #1;
        chk("R10 hi on", int'(bus_hi_oe), 1);
        chk("R10 lo on", int'(bus_lo_oe), 1);
        chk("R10 word", int'({bus_hi, bus_lo}), 345);
        sa_mode = 1'b0;
    endtask

    task automatic test_abort();
        int n;
        ain = 300; bipolar_sel = 1'b0;
        arm(1);
        @(negedge clk);
        repeat (5 * D) @(negedge clk);
        convert = 1'b1;
        ain = 900;
        @(negedge clk);
        chk("R11 dr stays high", int'(dr), 1);
        chk("R11 code cleared", int'(trial_code), 0);
        repeat (3) @(negedge clk);
        chk("R11 no restart while high", int'(trial_code), 0);
        convert = 1'b0;
        await_done(n);
        chk("R11 restart edges", n, DONE_EDGES);
        chk("R11 restart result", int'(trial_code), 900);
    endtask

    initial begin
        test_reset();
        test_idle_fall();
        test_convert(0, 1'b0, 1);
        test_convert(1023, 1'b0, 3);
        test_convert(700, 1'b0, 1);
        test_convert(1, 1'b0, 2);
        test_convert(2000, 1'b0, 1);
        test_trace(341);
        test_convert(-512, 1'b1, 1);
        test_convert(0, 1'b1, 1);
        test_convert(511, 1'b1, 1);
        test_convert(-1, 1'b1, 1);
        test_mode_latch();
        test_lanes();
        test_partial();
        test_standalone();
        test_abort();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule